// File: doc/BRIEF.md
# Accumulator ALU Execute Stage with Flag Update

This block is the execute stage for the accumulator-style data operations of a 14-bit instruction word. Each accepted instruction carries a 6-bit operation code in its top bits. Register forms follow the code with a destination bit and a 7-bit register address. Immediate forms follow it with an 8-bit literal. The stage takes the instruction, the current accumulator (W), the register operand already fetched by the surrounding core, and the current condition flags. One clock later it returns the 8-bit result, the destination select, the updated flag set and a skip request.

The stage does not read or write storage. The core uses the destination select to write the result either to the addressed register or to W, and it stores the returned flags. When the skip request is set, the core discards the next instruction. Carry and half-carry follow the add and subtract rules. Subtraction is the register minus W, computed as register plus inverted W plus one, so carry set means no borrow. The zero flag is updated only by the instructions that are defined to touch it.

Top module: `accalu_top`

## Requirements
- R1: An instruction sampled with `in_valid` high and a recognised operation code produces `out_valid` high exactly one clock later. `out_valid` is low the cycle after `in_valid` is low or the code is unrecognised (for example 000000). During active-low synchronous reset `out_valid`, `out_skip` and `out_result` are 0.
- R2: Add (code 011011) returns (reg + W) mod 256. Flags vector bit 0 is carry, bit 1 is half-carry and bit 2 is zero. Carry is the carry out of bit 7, half-carry is the carry out of bit 3, and zero is set when the result is 0.
- R3: Subtract (code 011100) returns (reg − W) mod 256. Carry is 1 when reg ≥ W (no borrow). Half-carry is 1 when reg[3:0] ≥ W[3:0]. Zero is set when the result is 0.
- R4: AND, OR and XOR with a register (codes 010010, 010011, 010100) return the bitwise result of reg and W. They update only zero; carry and half-carry are copied from `flags_in`.
- R5: Increment (011001) and decrement (011101) return reg ± 1 mod 256. They update only zero and never request a skip.
- R6: Increment-skip (011010) and decrement-skip (011110) return reg ± 1 mod 256 and leave all three flags equal to `flags_in`. They raise `out_skip` exactly when the result is 0.
- R7: Swap (010111) returns the operand with its two 4-bit halves exchanged and updates only zero.
- R8: Load (011000) returns the register operand unchanged and updates only zero.
- R9: The immediate forms take their operand from instruction bits 7:0. AND-immediate (110100) and OR-immediate (110101) combine it with W and update only zero. Load-immediate (111010) returns the literal and changes no flag.
- R10: For register forms `out_to_reg` equals instruction bit 7. For immediate forms it is 0, meaning the result goes to W.
- R11: `out_skip` is 0 for every instruction other than the two skip forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 14 | Instruction word: code [13:8], destination bit [7], address or literal below |
| w_in | input | 8 | Current accumulator value |
| reg_in | input | 8 | Register operand fetched by the core |
| flags_in | input | 3 | Current flags {zero, half-carry, carry} |
| out_valid | output | 1 | Result fields are valid |
| out_result | output | 8 | Operation result |
| out_to_reg | output | 1 | 1: write the register, 0: write W |
| out_flags | output | 3 | Updated flags {zero, half-carry, carry} |
| out_skip | output | 1 | Skip the next instruction |

## Verification
Every result field, together with `out_valid`, is due exactly one clock after the cycle in which the instruction was presented, because there is a single output register stage. The bench drives one instruction or idle slot on each falling edge and pushes the expected outcome of that slot at the same time, including an expected-invalid entry for idle and unrecognised slots. The monitor pops one entry shortly after each rising edge, so every comparison lines up with the cycle one register after the stimulus.

// File: rtl/accalu_pkg.sv
// Package: shared constants and types for the accumulator ALU stage.
// Assumes an 8-bit literal/address field below a 6-bit operation code.
package accalu_pkg;

    localparam int OPC_W  = 6;
    localparam int FLAG_W = 3;
    localparam int FLG_C  = 0;
    localparam int FLG_HC = 1;
    localparam int FLG_Z  = 2;

    localparam logic [OPC_W-1:0] OPC_ADD   = 6'b011011;
    localparam logic [OPC_W-1:0] OPC_SUB   = 6'b011100;
    localparam logic [OPC_W-1:0] OPC_AND   = 6'b010010;
    localparam logic [OPC_W-1:0] OPC_OR    = 6'b010011;
    localparam logic [OPC_W-1:0] OPC_XOR   = 6'b010100;
    localparam logic [OPC_W-1:0] OPC_INC   = 6'b011001;
    localparam logic [OPC_W-1:0] OPC_DEC   = 6'b011101;
    localparam logic [OPC_W-1:0] OPC_INCSZ = 6'b011010;
    localparam logic [OPC_W-1:0] OPC_DECSZ = 6'b011110;
    localparam logic [OPC_W-1:0] OPC_SWAP  = 6'b010111;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b011000;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'b110100;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'b110101;
    localparam logic [OPC_W-1:0] OPC_LDI   = 6'b111010;

    typedef enum logic [3:0] {
        K_NONE, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_INC, K_DEC,
        K_INCSZ, K_DECSZ, K_SWAP, K_LOAD, K_ANDI, K_ORI, K_LDI
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     known;
        logic     use_lit;
        logic     to_reg;
        logic     upd_z;
        logic     upd_ch;
        logic     skip_en;
    } dec_t;

endpackage

// File: rtl/accalu_decode.sv
// Module: accalu_decode
// Maps the operation code and destination bit to an operation kind and
// per-instruction control (operand source, destination, which flags change,
// skip eligibility). Purely combinational; unknown codes give known=0.
module accalu_decode
    import accalu_pkg::*;
#(
    parameter int INSTR_W = 14
) (
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    localparam int DEST_BIT = INSTR_W - OPC_W - 1;

    logic [OPC_W-1:0] opc;
    assign opc = instr[INSTR_W-1 -: OPC_W];

    // Select operation kind and control bits from the code.
    always_comb begin
        dec         = '0;
        dec.kind    = K_NONE;
        dec.known   = 1'b1;
        dec.to_reg  = instr[DEST_BIT];
        dec.upd_z   = 1'b1;
        case (opc)
            OPC_ADD:   begin dec.kind = K_ADD; dec.upd_ch = 1'b1; end
            OPC_SUB:   begin dec.kind = K_SUB; dec.upd_ch = 1'b1; end
            OPC_AND:   dec.kind = K_AND;
            OPC_OR:    dec.kind = K_OR;
            OPC_XOR:   dec.kind = K_XOR;
            OPC_INC:   dec.kind = K_INC;
            OPC_DEC:   dec.kind = K_DEC;
            OPC_INCSZ: begin dec.kind = K_INCSZ; dec.upd_z = 1'b0; dec.skip_en = 1'b1; end
            OPC_DECSZ: begin dec.kind = K_DECSZ; dec.upd_z = 1'b0; dec.skip_en = 1'b1; end
            OPC_SWAP:  dec.kind = K_SWAP;
            OPC_LOAD:  dec.kind = K_LOAD;
            OPC_ANDI:  begin dec.kind = K_ANDI; dec.use_lit = 1'b1; dec.to_reg = 1'b0; end
            OPC_ORI:   begin dec.kind = K_ORI;  dec.use_lit = 1'b1; dec.to_reg = 1'b0; end
            OPC_LDI:   begin
                dec.kind = K_LDI; dec.use_lit = 1'b1; dec.to_reg = 1'b0; dec.upd_z = 1'b0;
            end
            default:   begin dec.known = 1'b0; dec.upd_z = 1'b0; dec.to_reg = 1'b0; end
        endcase
    end

endmodule

// File: rtl/accalu_arith.sv
// Module: accalu_arith
// Computes the result for one operation kind. A single adder serves add,
// subtract (operand + ~W + 1), increment and decrement; carry and
// half-carry come from that adder. Assumes DATA_W is even.
module accalu_arith
    import accalu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_kind_e          kind,
    input  logic [DATA_W-1:0] opnd,
    input  logic [DATA_W-1:0] w,
    output logic [DATA_W-1:0] res,
    output logic              carry,
    output logic              half
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] add_b;
    logic              cin;
    logic [DATA_W:0]   sum;
    logic [HALF_W:0]   lo_sum;

    // Pick the second adder input and carry-in for the arithmetic kinds.
    always_comb begin
        add_b = w;
        cin   = 1'b0;
        case (kind)
            K_SUB:           begin add_b = ~w;          cin = 1'b1; end
            K_INC, K_INCSZ:  begin add_b = '0;          cin = 1'b1; end
            K_DEC, K_DECSZ:  begin add_b = '1;          cin = 1'b0; end
            default:         begin add_b = w;           cin = 1'b0; end
        endcase
    end

    // Full-width and low-half sums share one carry-in.
    always_comb begin
        sum    = {1'b0, opnd} + {1'b0, add_b} + {{DATA_W{1'b0}}, cin};
        lo_sum = {1'b0, opnd[HALF_W-1:0]} + {1'b0, add_b[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
        carry  = sum[DATA_W];
        half   = lo_sum[HALF_W];
    end

    // Route the selected function to the result.
    always_comb begin
        case (kind)
            K_ADD, K_SUB, K_INC, K_DEC, K_INCSZ, K_DECSZ: res = sum[DATA_W-1:0];
            K_AND, K_ANDI: res = opnd & w;
            K_OR,  K_ORI:  res = opnd | w;
            K_XOR:         res = opnd ^ w;
            K_SWAP:        res = {opnd[HALF_W-1:0], opnd[DATA_W-1:HALF_W]};
            K_LOAD, K_LDI: res = opnd;
            default:       res = '0;
        endcase
    end

endmodule

// File: rtl/accalu_flags.sv
// Module: accalu_flags
// Builds the next flag set from the incoming flags and the per-instruction
// update enables, and forms the skip request. Combinational.
module accalu_flags
    import accalu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  dec_t              dec,
    input  logic [DATA_W-1:0] res,
    input  logic              carry,
    input  logic              half,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [FLAG_W-1:0] flags_nxt,
    output logic              skip
);
    logic is_zero;
    assign is_zero = (res == '0);

    // Overlay only the flags this instruction is allowed to change.
    always_comb begin
        flags_nxt = flags_in;
        if (dec.upd_ch) begin
            flags_nxt[FLG_C]  = carry;
            flags_nxt[FLG_HC] = half;
        end
        if (dec.upd_z) begin
            flags_nxt[FLG_Z] = is_zero;
        end
    end

    // Skip is requested only by the skip forms on a zero result.
    always_comb skip = dec.skip_en & is_zero;

endmodule

// File: rtl/accalu_top.sv
// Module: accalu_top
// Execute stage for accumulator data operations: decode, compute and flag
// update in one combinational pass, then one output register. Result is
// valid one clock after an accepted instruction. Assumes INSTR_W equals
// the code width plus DATA_W (destination bit plus address, or literal).
module accalu_top
    import accalu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int INSTR_W = OPC_W + DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  w_in,
    input  logic [DATA_W-1:0]  reg_in,
    input  logic [FLAG_W-1:0]  flags_in,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_result,
    output logic               out_to_reg,
    output logic [FLAG_W-1:0]  out_flags,
    output logic               out_skip
);
    dec_t              dec;
    logic [DATA_W-1:0] opnd;
    logic [DATA_W-1:0] res;
    logic              carry;
    logic              half;
    logic [FLAG_W-1:0] flags_nxt;
    logic              skip;

    accalu_decode #(.INSTR_W(INSTR_W)) u_dec (
        .instr (instr),
        .dec   (dec)
    );

    // Operand source: literal field for immediate forms, else the register.
    always_comb opnd = dec.use_lit ? instr[DATA_W-1:0] : reg_in;

    accalu_arith #(.DATA_W(DATA_W)) u_arith (
        .kind  (dec.kind),
        .opnd  (opnd),
        .w     (w_in),
        .res   (res),
        .carry (carry),
        .half  (half)
    );

    accalu_flags #(.DATA_W(DATA_W)) u_flags (
        .dec       (dec),
        .res       (res),
        .carry     (carry),
        .half      (half),
        .flags_in  (flags_in),
        .flags_nxt (flags_nxt),
        .skip      (skip)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_to_reg <= 1'b0;
            out_flags  <= '0;
            out_skip   <= 1'b0;
        end else begin
            out_valid  <= in_valid & dec.known;
            out_result <= res;
            out_to_reg <= dec.to_reg;
            out_flags  <= flags_nxt;
            out_skip   <= in_valid & dec.known & skip;
        end
    end

endmodule

// File: rtl/accalu_chk.sv
// Module: accalu_chk
// Property checker for accalu_top, attached by bind. Observes ports only.
module accalu_chk
    import accalu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int INSTR_W = OPC_W + DATA_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [INSTR_W-1:0] instr,
    input logic [DATA_W-1:0]  w_in,
    input logic [DATA_W-1:0]  reg_in,
    input logic [FLAG_W-1:0]  flags_in,
    input logic               out_valid,
    input logic [DATA_W-1:0]  out_result,
    input logic               out_to_reg,
    input logic [FLAG_W-1:0]  out_flags,
    input logic               out_skip
);
    localparam int HALF_W = DATA_W / 2;

    logic [OPC_W-1:0] opc;
    assign opc = instr[INSTR_W-1 -: OPC_W];

    // R1: no valid output without an instruction the cycle before
    a_r1_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R6: a skip request only accompanies a zero result
    a_r6_skip_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_skip |-> (out_valid && out_result == '0));

    // R6: skip forms leave every flag untouched
    a_r6_skip_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opc == OPC_INCSZ || opc == OPC_DECSZ)) |=> out_flags == $past(flags_in));

    // R10: immediate forms always target W
    a_r10_imm_to_w: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opc == OPC_ANDI || opc == OPC_ORI || opc == OPC_LDI)) |=> !out_to_reg);

    // R7: swap exchanges the two halves of the operand
    a_r7_swap_halves: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc == OPC_SWAP) |=>
            out_result == {$past(reg_in[HALF_W-1:0]), $past(reg_in[DATA_W-1:HALF_W])});

    // R9: load-immediate returns the literal with flags unchanged
    a_r9_ldi_literal: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc == OPC_LDI) |=>
            (out_result == $past(instr[DATA_W-1:0]) && out_flags == $past(flags_in)));

endmodule

bind accalu_top accalu_chk #(.DATA_W(DATA_W), .INSTR_W(INSTR_W)) u_chk (.*);

// File: tb/sim_accalu_top.sv
// Scoreboard bench for accalu_top: the driver pushes one expected entry per
// driven slot, the monitor pops one entry after each rising edge.
module sim_accalu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [13:0] instr = '0;
    logic [7:0]  w_in = '0;
    logic [7:0]  reg_in = '0;
    logic [2:0]  flags_in = '0;
    logic        out_valid;
    logic [7:0]  out_result;
    logic        out_to_reg;
    logic [2:0]  out_flags;
    logic        out_skip;

    int total = 0;
    int bad = 0;
    bit running = 1'b0;

    typedef struct packed {
        logic       v;
        logic [7:0] res;
        logic       dst;
        logic [2:0] fl;
        logic       sk;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];

    always #2 clk = ~clk;   // 250 MHz

    accalu_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .w_in(w_in), .reg_in(reg_in), .flags_in(flags_in),
        .out_valid(out_valid), .out_result(out_result), .out_to_reg(out_to_reg),
        .out_flags(out_flags), .out_skip(out_skip)
    );

    // Reference model written from the requirements (flags {Z,HC,C}).
    function automatic exp_t model(logic [13:0] ins, logic [7:0] w, logic [7:0] r, logic [2:0] f);
        exp_t e;
        logic [8:0] s;
        logic [7:0] lit;
        lit = ins[7:0];
        e = '0; e.v = 1'b1; e.fl = f; e.dst = ins[7];
        case (ins[13:8])
            6'b011011: begin s = {1'b0, r} + {1'b0, w}; e.res = s[7:0];
                e.fl[0] = s[8]; e.fl[1] = ({1'b0, r[3:0]} + {1'b0, w[3:0]}) > 5'd15;
                e.fl[2] = (e.res == 0); end
            6'b011100: begin e.res = r - w; e.fl[0] = (r >= w); e.fl[1] = (r[3:0] >= w[3:0]);
                e.fl[2] = (e.res == 0); end
            6'b010010: begin e.res = r & w; e.fl[2] = (e.res == 0); end
            6'b010011: begin e.res = r | w; e.fl[2] = (e.res == 0); end
            6'b010100: begin e.res = r ^ w; e.fl[2] = (e.res == 0); end
            6'b011001: begin e.res = r + 8'd1; e.fl[2] = (e.res == 0); end
            6'b011101: begin e.res = r - 8'd1; e.fl[2] = (e.res == 0); end
            6'b011010: begin e.res = r + 8'd1; e.sk = (e.res == 0); end
            6'b011110: begin e.res = r - 8'd1; e.sk = (e.res == 0); end
            6'b010111: begin e.res = {r[3:0], r[7:4]}; e.fl[2] = (e.res == 0); end
            6'b011000: begin e.res = r; e.fl[2] = (e.res == 0); end
            6'b110100: begin e.res = lit & w; e.dst = 1'b0; e.fl[2] = (e.res == 0); end
            6'b110101: begin e.res = lit | w; e.dst = 1'b0; e.fl[2] = (e.res == 0); end
            6'b111010: begin e.res = lit; e.dst = 1'b0; end
            default:   e = '0;
        endcase
        return e;
    endfunction

    task automatic drive(input logic [5:0] opc, input logic [7:0] low,
                         input logic [7:0] w, input logic [7:0] r,
                         input logic [2:0] f, input string tag);
        @(negedge clk);
        in_valid = 1'b1; instr = {opc, low}; w_in = w; reg_in = r; flags_in = f;
        expq.push_back(model({opc, low}, w, r, f));
        tagq.push_back(tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        in_valid = 1'b0; instr = {6'b011011, 8'h00};
        expq.push_back('0);
        tagq.push_back(tag);
    endtask

    task automatic report(input string tag, input exp_t a, input exp_t e);
        total++;
        if (a !== e) begin
            bad++;
            $display("FAIL %s actual v=%b res=%h dst=%b fl=%b sk=%b expected v=%b res=%h dst=%b fl=%b sk=%b",
                     tag, a.v, a.res, a.dst, a.fl, a.sk, e.v, e.res, e.dst, e.fl, e.sk);
        end
    endtask

    // Monitor: one entry per rising edge, sampled after the register update.
    always @(posedge clk) begin
        #1;
        if (running && expq.size() > 0) begin
            exp_t e;
            exp_t a;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            a.v = out_valid; a.sk = out_skip;
            if (e.v) begin
                a.res = out_result; a.dst = out_to_reg; a.fl = out_flags;
            end else begin
                a.res = '0; a.dst = 1'b0; a.fl = '0;
            end
            report(t, a, e);
        end
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;   // R1: reset state
        if (out_valid !== 1'b0 || out_skip !== 1'b0 || out_result !== 8'h00) begin
            bad++;
            $display("FAIL R1 reset actual v=%b sk=%b res=%h expected v=0 sk=0 res=00",
                     out_valid, out_skip, out_result);
        end
        @(negedge clk); rst_n = 1'b1; running = 1'b1;

        drive(6'b011011, 8'h85, 8'h01, 8'h0F, 3'b000, "R2 add half-carry");
        drive(6'b011011, 8'h05, 8'h01, 8'hFF, 3'b000, "R2 add wrap zero");
        drive(6'b011011, 8'h85, 8'h20, 8'h10, 3'b111, "R2 add plain");
        drive(6'b011100, 8'h85, 8'h05, 8'h05, 3'b000, "R3 sub equal");
        drive(6'b011100, 8'h05, 8'h05, 8'h03, 3'b111, "R3 sub borrow");
        drive(6'b011100, 8'h85, 8'h01, 8'h10, 3'b000, "R3 sub nibble borrow");
        drive(6'b010010, 8'h81, 8'hF0, 8'h0F, 3'b011, "R4 and zero");
        drive(6'b010011, 8'h01, 8'hA0, 8'h05, 3'b101, "R4 or");
        drive(6'b010100, 8'h81, 8'h5A, 8'h5A, 3'b010, "R4 xor zero");
        drive(6'b011001, 8'h82, 8'h00, 8'hFF, 3'b011, "R5 inc wrap");
        drive(6'b011101, 8'h02, 8'h00, 8'h01, 3'b000, "R5 dec to zero");
        drive(6'b011010, 8'h83, 8'h00, 8'hFF, 3'b011, "R6 incsz skip");
        drive(6'b011110, 8'h83, 8'h00, 8'h02, 3'b100, "R6 decsz no skip");
        drive(6'b011110, 8'h03, 8'h00, 8'h01, 3'b010, "R6 decsz skip");
        drive(6'b010111, 8'h84, 8'h00, 8'hA5, 3'b100, "R7 swap");
        drive(6'b011000, 8'h04, 8'h00, 8'h00, 3'b011, "R8 load zero");
        drive(6'b011000, 8'h84, 8'h00, 8'h3C, 3'b100, "R8 load nonzero");
        drive(6'b110100, 8'h0F, 8'hF0, 8'hFF, 3'b011, "R9 and-immediate zero");
        drive(6'b110101, 8'h81, 8'h10, 8'h00, 3'b100, "R9 or-immediate");
        drive(6'b111010, 8'h00, 8'h55, 8'h55, 3'b101, "R9 load-immediate flags kept");
        drive(6'b011011, 8'h00, 8'h02, 8'h03, 3'b000, "R10 destination W");
        drive(6'b011001, 8'h80, 8'h00, 8'h41, 3'b000, "R11 inc no skip on nonzero");
        drive(6'b000000, 8'h00, 8'h00, 8'h00, 3'b000, "R1 unknown code");
        idle("R1 idle slot");
        drive(6'b011011, 8'h80, 8'h80, 8'h80, 3'b000, "R2 add carry zero after gap");
        idle("R1 drain");
        idle("R1 drain");

        running = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule